// File: doc/BRIEF.md
# Modulated Delay Chorus/Flanger

This block is a streaming audio effect for chorus and flange sounds. Each accepted 16-bit signed sample goes into a short circular delay line. A tap is read from that line at a fractional distance behind the newest sample. A low-frequency oscillator (LFO) sweeps the distance, and the tap value is the block's output. The same tap value, scaled by a regeneration factor, is also combined with the incoming sample before it is stored. This feedback produces the comb-filter colouring typical of flangers. A control flag changes the feedback from an addition into a subtraction, which moves the comb notches.

Samples enter and leave over valid/ready handshakes. A transfer happens on a clock edge where both valid and ready are high. The input side is ready whenever the output register is empty or is being drained in that cycle. When the consumer holds `out_ready` low while a result is waiting, the whole pipeline freezes. The held result stays stable and no new sample is accepted. The controls are plain level inputs. Depth, rate and regeneration are unsigned Q15 magnitudes: 0 means 0.0 and 0x7FFF means just under 1.0. All controls are captured together with the sample on its accept edge.

Top module: `mod_delay_fx`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sample` stays unchanged.
- R2: A sample accepted on edge N has its result on `out_valid`/`out_sample` from edge N+3, provided `in_ready` is high at edges N+1 to N+3. A back-pressure stall adds one cycle per stalled edge. Results leave in acceptance order and are never duplicated or invented.
- R3: The delay line holds the last DEPTH stored values w[n]. Positions older than the first sample after reset read as zero. The controls used for sample n are those present on its accept edge.
- R4: The tap distance, in 1/256-sample units, is BASE_DLY*256 + ((depth*L) >> 13), where L is the LFO value (0..32767). The result is clamped to at most (DEPTH-1)*256. Its integer part is k and its low 8 bits are f.
- R5: The output is y[n] = floor((w[n-k]*(256-f) + w[n-k-1]*f) / 256).
- R6: The feedback term is fb = floor(regen*y[n] / 32768). The stored value is w[n] = x[n] + fb when `fb_invert` is 0, and x[n] - fb when it is 1.
- R7: A 16-bit phase accumulator is zero after reset. Sample n uses the phase before its own step. Every accepted sample adds `rate_q15` to the phase, modulo 65536.
- R8: Let v be the phase. Let x be v[14:0] when v[15] is 0, and ~v[14:0] when v[15] is 1. The LFO value for each `lfo_shape` code is: 00 smooth sine-like, (x*(65535-x))>>15; 01 triangle, x; 10 inverted rectified sine, 32767-((v[14:0]*(32767-v[14:0]))>>13); 11 trapezoid, 2x-16384 clamped to 0..32767.
- R9: The stored sum of R6 saturates to -32768..32767 and never wraps.
- R10: During and right after reset, `out_valid` is low, `in_ready` is high and `out_sample` is zero. The delay line reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 16 | Signed input sample |
| depth_q15 | input | 15 | Sweep depth, Q15 magnitude |
| rate_q15 | input | 15 | LFO phase step per sample |
| regen_q15 | input | 15 | Feedback amount, Q15 magnitude |
| lfo_shape | input | 2 | LFO waveform select (R8 codes) |
| fb_invert | input | 1 | 1 subtracts the feedback term |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_sample | output | 16 | Signed delayed (wet) sample |

## Verification
The hardest case to reach from the ports is a tap read of a value that is still inside the pipeline. This occurs when the tap is two samples back, samples arrive back-to-back, and back-pressure freezes the stages at random points. The bench uses a base delay of 2 with zero depth to force that minimum distance. It then sweeps the full depth with random gaps in both handshakes. It also drives loud inputs at full regeneration, in both feedback polarities, until the stored sum saturates.

// File: rtl/cfx_pkg.sv
package cfx_pkg;

  typedef logic signed [15:0] sample_t;

  typedef enum logic [1:0] {
    SHP_SINE  = 2'b00,
    SHP_TRI   = 2'b01,
    SHP_IRECT = 2'b10,
    SHP_TRAP  = 2'b11
  } lfo_shape_e;

  // Clip a wide signed sum into the 16-bit sample range.
  function automatic sample_t sat16(input logic signed [31:0] v);
    if (v > 32'sd32767)
      return 16'sh7fff;
    else if (v < -32'sd32768)
      return 16'sh8000;
    else
      return 16'(v);
  endfunction

  // Unipolar LFO value (0..32767) computed from the 16-bit phase.
  function automatic logic [14:0] lfo_value(input logic [15:0] ph, input lfo_shape_e shp);
    logic [14:0]        fold;
    logic [14:0]        half;
    logic signed [31:0] ramp;
    logic [14:0]        res;
    fold = ph[15] ? ~ph[14:0] : ph[14:0];
    half = ph[14:0];
    ramp = $signed(32'(fold) << 1) - 32'sd16384;
    case (shp)
      SHP_SINE:  res = 15'((32'(fold) * (32'd65535 - 32'(fold))) >> 15);
      SHP_TRI:   res = fold;
      SHP_IRECT: res = 15'(32'd32767 - ((32'(half) * (32'd32767 - 32'(half))) >> 13));
      default: begin
        if (ramp < 0)
          res = '0;
        else if (ramp > 32'sd32767)
          res = 15'h7fff;
        else
          res = 15'(ramp);
      end
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cfx_lfo.sv
module cfx_lfo
  import cfx_pkg::*;
#(
  parameter int RATE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [RATE_W-1:0] rate,
  input  logic [1:0]        shape,
  output logic [14:0]       lfo
);

  localparam int PH_W = 16;

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase_q <= '0;
    else if (step)
      phase_q <= phase_q + PH_W'(rate);
  end

  // Value reflects the phase before this sample's own step.
  assign lfo = lfo_value(phase_q, lfo_shape_e'(shape));

endmodule

// File: rtl/cfx_delay_mem.sv
module cfx_delay_mem #(
  parameter int DEPTH = 1024,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/cfx_interp.sv
module cfx_interp #(
  parameter int W      = 16,
  parameter int FRAC_W = 8
) (
  input  logic signed [W-1:0] near_s,
  input  logic signed [W-1:0] far_s,
  input  logic [FRAC_W-1:0]   frac,
  output logic signed [W-1:0] y
);

  localparam logic [FRAC_W:0] ONE = {1'b1, {FRAC_W{1'b0}}};

  logic [FRAC_W:0]              w_near;
  logic [FRAC_W:0]              w_far;
  logic signed [W+FRAC_W:0]     acc;

  always_comb begin
    w_near = ONE - {1'b0, frac};
    w_far  = {1'b0, frac};
    acc    = near_s * $signed({1'b0, w_near}) + far_s * $signed({1'b0, w_far});
    y      = W'(acc >>> FRAC_W);
  end

endmodule

// File: rtl/mod_delay_fx.sv
module mod_delay_fx
  import cfx_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int BASE_DLY    = 64,
  parameter int FRAC_W      = 8,
  parameter int SWEEP_SHIFT = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic signed [15:0] in_sample,
  input  logic [14:0]        depth_q15,
  input  logic [14:0]        rate_q15,
  input  logic [14:0]        regen_q15,
  input  logic [1:0]         lfo_shape,
  input  logic               fb_invert,
  output logic               out_valid,
  input  logic               out_ready,
  output logic signed [15:0] out_sample
);

  localparam int AW           = $clog2(DEPTH);
  localparam int FX_W         = AW + FRAC_W;
  localparam logic [31:0] BASE_FX = 32'(BASE_DLY) << FRAC_W;
  localparam logic [31:0] MAX_FX  = 32'(DEPTH - 1) << FRAC_W;

  // Handshake
  logic    advance;
  logic    fire;
  logic    out_valid_q;
  sample_t out_q;

  assign advance    = !out_valid_q || out_ready;
  assign in_ready   = advance;
  assign fire       = in_valid && advance;
  assign out_valid  = out_valid_q;
  assign out_sample = out_q;

  // LFO
  logic [14:0] lfo_now;

  cfx_lfo #(.RATE_W(15)) u_lfo (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (fire),
    .rate  (rate_q15),
    .shape (lfo_shape),
    .lfo   (lfo_now)
  );

  // Pipeline registers
  logic [AW-1:0] seq_q;

  logic          s0_v, s0_inv;
  sample_t       s0_x;
  logic [14:0]   s0_lfo, s0_dep, s0_regen;
  logic [AW-1:0] s0_seq;

  logic          s1_v, s1_inv;
  sample_t       s1_x;
  logic [14:0]   s1_regen;
  logic [AW-1:0] s1_seq;
  logic [FX_W-1:0] s1_fx;

  logic          s2_v, s2_inv;
  sample_t       s2_x, s2_y;
  logic [14:0]   s2_regen;
  logic [AW-1:0] s2_seq;

  // Stage 0 -> 1: tap distance
  logic [29:0]     sweep_prod;
  logic [31:0]     fx_sum;
  logic [FX_W-1:0] fx_next;

  always_comb begin
    sweep_prod = s0_dep * s0_lfo;
    fx_sum     = BASE_FX + 32'(sweep_prod >> SWEEP_SHIFT);
    fx_next    = (fx_sum > MAX_FX) ? FX_W'(MAX_FX) : FX_W'(fx_sum);
  end

  // Stage 1 -> 2: tap read and interpolation
  logic [AW-1:0] rd_a, rd_b;
  logic [15:0]   tap_a, tap_b;
  sample_t       y_next;

  assign rd_a = s1_seq - s1_fx[FX_W-1:FRAC_W];
  assign rd_b = rd_a - AW'(1);

  cfx_interp #(.W(16), .FRAC_W(FRAC_W)) u_interp (
    .near_s (tap_a),
    .far_s  (tap_b),
    .frac   (s1_fx[FRAC_W-1:0]),
    .y      (y_next)
  );

  // Stage 2 -> out: feedback and write-back
  logic signed [31:0] x_ext, fb_full, fb_term, fb_sum;
  sample_t            w_next;
  logic               mem_we;

  always_comb begin
    x_ext   = s2_x;
    fb_full = $signed({1'b0, s2_regen}) * s2_y;
    fb_term = fb_full >>> 15;
    fb_sum  = s2_inv ? (x_ext - fb_term) : (x_ext + fb_term);
    w_next  = sat16(fb_sum);
  end

  assign mem_we = advance && s2_v;

  cfx_delay_mem #(.DEPTH(DEPTH), .W(16)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mem_we),
    .waddr   (s2_seq),
    .wdata   (w_next),
    .raddr_a (rd_a),
    .raddr_b (rd_b),
    .rdata_a (tap_a),
    .rdata_b (tap_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q       <= '0;
      s0_v        <= 1'b0;
      s0_inv      <= 1'b0;
      s0_x        <= '0;
      s0_lfo      <= '0;
      s0_dep      <= '0;
      s0_regen    <= '0;
      s0_seq      <= '0;
      s1_v        <= 1'b0;
      s1_inv      <= 1'b0;
      s1_x        <= '0;
      s1_regen    <= '0;
      s1_seq      <= '0;
      s1_fx       <= '0;
      s2_v        <= 1'b0;
      s2_inv      <= 1'b0;
      s2_x        <= '0;
      s2_y        <= '0;
      s2_regen    <= '0;
      s2_seq      <= '0;
      out_valid_q <= 1'b0;
      out_q       <= '0;
    end else if (advance) begin
      if (fire)
        seq_q <= seq_q + AW'(1);
      s0_v        <= fire;
      s0_inv      <= fb_invert;
      s0_x        <= in_sample;
      s0_lfo      <= lfo_now;
      s0_dep      <= depth_q15;
      s0_regen    <= regen_q15;
      s0_seq      <= seq_q;
      s1_v        <= s0_v;
      s1_inv      <= s0_inv;
      s1_x        <= s0_x;
      s1_regen    <= s0_regen;
      s1_seq      <= s0_seq;
      s1_fx       <= fx_next;
      s2_v        <= s1_v;
      s2_inv      <= s1_inv;
      s2_x        <= s1_x;
      s2_y        <= y_next;
      s2_regen    <= s1_regen;
      s2_seq      <= s1_seq;
      out_valid_q <= s2_v;
      out_q       <= s2_y;
    end
  end

endmodule

// File: rtl/cfx_checker.sv
module cfx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_sample,
  input logic        mem_we
);

  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)
      since_rst <= '0;
    else if (since_rst != 3'd7)
      since_rst <= since_rst + 3'd1;
  end

  // R1: a held result does not move or vanish under back-pressure
  p_hold_under_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  // R2: accepted sample emerges three advancing edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 in_ready ##1 in_ready ##1 in_ready |=> out_valid);

  // R2: a fresh result is backed by an accept four advancing edges earlier
  p_no_phantom_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd5 && $rose(out_valid) && $past(in_ready, 1) && $past(in_ready, 2)
     && $past(in_ready, 3) && $past(in_ready, 4)) |-> $past(in_valid && in_ready, 4));

  // R3: every delay-line write goes with a presented result
  p_write_then_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> out_valid);

endmodule

bind mod_delay_fx cfx_checker u_cfx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sample (out_sample),
  .mem_we     (mem_we)
);

// File: tb/mod_delay_fx_tb_top.sv
module mod_delay_fx_tb_top;

  localparam int DEPTH_T = 256;
  localparam int BASE_T  = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [15:0] in_sample = '0;
  logic [14:0]        depth_q15 = '0;
  logic [14:0]        rate_q15 = '0;
  logic [14:0]        regen_q15 = '0;
  logic [1:0]         lfo_shape = '0;
  logic               fb_invert = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic signed [15:0] out_sample;

  always #5 clk = ~clk;

  mod_delay_fx #(.DEPTH(DEPTH_T), .BASE_DLY(BASE_T)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sample  (in_sample),
    .depth_q15  (depth_q15),
    .rate_q15   (rate_q15),
    .regen_q15  (regen_q15),
    .lfo_shape  (lfo_shape),
    .fb_invert  (fb_invert),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  // Control values applied at the next driving point
  int c_depth = 0, c_rate = 0, c_regen = 0, c_shape = 0;
  bit c_inv = 0;
  string tag = "R3";

  // Reference model state
  int hist[$];
  int ph = 0;
  bit mv0 = 0, mv1 = 0, mv2 = 0, mvo = 0;
  int md0 = 0, md1 = 0, md2 = 0, mdo = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int lfo_ref(input int p, input int shp);
    int fold, half, r;
    fold = (p & 32'h8000) ? ((~p) & 32'h7fff) : (p & 32'h7fff);
    half = p & 32'h7fff;
    case (shp)
      0: r = (fold * (65535 - fold)) >>> 15;
      1: r = fold;
      2: r = 32767 - ((half * (32767 - half)) >>> 13);
      default: begin
        r = 2 * fold - 16384;
        if (r < 0) r = 0;
        if (r > 32767) r = 32767;
      end
    endcase
    return r;
  endfunction

  function automatic int clip(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int model_accept(input int x);
    int lf, fx, k, f, n, a, b, y, fb, w;
    lf = lfo_ref(ph, c_shape);
    ph = (ph + c_rate) & 32'hffff;
    fx = BASE_T * 256 + ((c_depth * lf) >>> 13);
    if (fx > (DEPTH_T - 1) * 256) fx = (DEPTH_T - 1) * 256;
    k = fx >>> 8;
    f = fx & 255;
    n = hist.size();
    a = (n - k >= 0) ? hist[n - k] : 0;
    b = (n - k - 1 >= 0) ? hist[n - k - 1] : 0;
    y = (a * (256 - f) + b * f) >>> 8;
    fb = (c_regen * y) >>> 15;
    w = clip(c_inv ? (x - fb) : (x + fb));
    hist.push_back(w);
    return y;
  endfunction

  // One clock: compare at the falling edge, then drive and advance the model.
  task automatic cycle(input bit iv, input int x, input bit ordy);
    bit adv, fr;
    int y;
    @(negedge clk);
    chk(out_valid === mvo, "R2", "out_valid", int'(out_valid), int'(mvo));
    chk(in_ready === (!mvo || out_ready), "R1", "in_ready", int'(in_ready), int'(!mvo || out_ready));
    if (mvo)
      chk(int'(out_sample) == mdo, tag, "out_sample", int'(out_sample), mdo);
    in_valid  = iv;
    in_sample = 16'(x);
    out_ready = ordy;
    depth_q15 = 15'(c_depth);
    rate_q15  = 15'(c_rate);
    regen_q15 = 15'(c_regen);
    lfo_shape = 2'(c_shape);
    fb_invert = c_inv;
    adv = !mvo || ordy;
    fr  = iv && adv;
    y   = 0;
    if (adv) begin
      if (fr) y = model_accept(x);
      mvo = mv2; mdo = md2;
      mv2 = mv1; md2 = md1;
      mv1 = mv0; md1 = md0;
      mv0 = fr;  md0 = y;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid === 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R10", "in_ready in reset", int'(in_ready), 1);
    chk(out_sample === 16'sd0, "R10", "out_sample in reset", int'(out_sample), 0);
    rst_n = 1'b1;

    // R3/R6/R10: shortest tap, steady stream, zeroed history at start
    tag = "R3/R6/R10";
    c_shape = 1; c_depth = 0; c_rate = 256; c_regen = 16384; c_inv = 0;
    for (int i = 0; i < 200; i++)
      cycle(1'b1, ((i * 97) % 4000) - 2000, 1'b1);

    // R4/R5/R7/R8: full sweep per shape with random gaps on both sides
    tag = "R4/R5/R7/R8";
    for (int s = 0; s < 4; s++) begin
      c_shape = s; c_depth = 32767; c_rate = 1100 + s * 300; c_regen = 12000;
      for (int i = 0; i < 250; i++)
        cycle(($urandom % 4) != 0, int'($urandom_range(40000, 0)) - 20000, ($urandom % 4) != 0);
      c_depth = 9000;
      for (int i = 0; i < 120; i++)
        cycle(($urandom % 3) != 0, int'($urandom_range(40000, 0)) - 20000, ($urandom % 3) != 0);
    end

    // R1/R2: long stall with a full pipeline, then release
    tag = "R1/R2";
    for (int i = 0; i < 20; i++)
      cycle(1'b1, 1000 + i, 1'b0);
    for (int i = 0; i < 30; i++)
      cycle(i < 10, 500 - i, 1'b1);

    // R9/R6: loud input at full regeneration, both polarities
    tag = "R9/R6";
    c_shape = 0; c_depth = 4000; c_rate = 700; c_regen = 32767;
    for (int pass = 0; pass < 2; pass++) begin
      c_inv = pass[0];
      for (int i = 0; i < 200; i++)
        cycle(1'b1, (i % 2 == 0) ? 32000 : -32000 + (i % 7) * 1000, ($urandom % 5) != 0);
    end

    tag = "R2";
    for (int i = 0; i < 10; i++)
      cycle(1'b0, 0, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule